// File: doc/BRIEF.md
# Oversampling Clock-Enable Divider with Half-Step Ratio

This block turns a fast system clock into the clock enables that pace an audio converter. A 3-bit ratio selector picks how many system-clock cycles make up one period of the 256x-rate enable. The supported ratios are 1, 2, 3, 4, 5.5 and 6. A second stage halves that enable to give a 128x-rate enable. Both outputs are single-cycle pulses in the system clock domain, so downstream logic stays on one clock and uses them as enables.

The 5.5 ratio is not an integer. It is made by alternating periods of 5 and 6 cycles, so every pair of pulses spans 11 cycles. Two selector values have no ratio. They fall back to a ratio of 1 and set a flag that stays high until reset. The selector can change while the block runs. A new value is taken only at the edge that ends a 256x period, so a period already under way always finishes at its old length.

Top module: `osr_clk_div`

## Requirements
- R1: While `rst_n` is low, `tick_256`, `tick_128` and `ratio_err` are all 0. After release the block starts with a ratio of 1, whatever the selector holds.
- R2: Selector value 3'b000 gives a `tick_256` pulse on every cycle.
- R3: Selector values 3'b010, 3'b011, 3'b100 and 3'b110 give `tick_256` periods of 2, 3, 4 and 6 cycles.
- R4: Selector value 3'b101 gives `tick_256` periods that alternate 5, 6, 5, 6. The first period after entering this ratio from any other ratio is 5.
- R5: Selector values 3'b001 and 3'b111 give a ratio of 1, so there is a pulse on every cycle.
- R6: `ratio_err` goes to 1 once a selector value of 3'b001 or 3'b111 is taken at a period boundary. It then stays at 1 until reset, whatever the selector does afterwards.
- R7: The selector is sampled only on the clock edge that ends a cycle in which `tick_256` is high. A change made partway through a period leaves that period at its old length.
- R8: `tick_128` is high only in cycles in which `tick_256` is high. It is high on the 2nd, 4th, 6th and later even-numbered `tick_256` pulses counted from reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ratio_sel | input | 3 | Ratio selector code |
| tick_256 | output | 1 | One-cycle enable at the 256x sample rate |
| tick_128 | output | 1 | One-cycle enable at half the 256x rate |
| ratio_err | output | 1 | Sticky flag: a reserved selector value was taken |

## Verification
The bench builds the block with the package default for the counter width, `LEN_W = 4`. That width is enough for the longest period of 6 cycles, and it lets the alternating 5/6 sequence run for many pairs within a short test. With this build the bench reaches every selector value, including both reserved ones. It also reaches a selector change made partway through a 6-cycle period, and entry into and exit from the half-step ratio. Running a second reset cycle shows that the sticky flag and the 128x phase both start again from a clean state.

// File: rtl/osr_div_pkg.sv
package osr_div_pkg;

  // Width of the period counter and of period lengths.
  localparam int LEN_W = 4;

  typedef enum logic [2:0] {
    M_ONE,
    M_TWO,
    M_THREE,
    M_FOUR,
    M_FIVE_HALF,
    M_SIX
  } div_mode_e;

  typedef struct packed {
    div_mode_e mode;
    logic      reserved;
  } sel_t;

  // Maps a selector code onto a divide mode. Unassigned codes run at ratio 1
  // and are marked as reserved.
  function automatic sel_t decode_sel(input logic [2:0] code);
    sel_t s;
    s.reserved = 1'b0;
    case (code)
      3'b000:  s.mode = M_ONE;
      3'b010:  s.mode = M_TWO;
      3'b011:  s.mode = M_THREE;
      3'b100:  s.mode = M_FOUR;
      3'b101:  s.mode = M_FIVE_HALF;
      3'b110:  s.mode = M_SIX;
      default: begin
        s.mode     = M_ONE;
        s.reserved = 1'b1;
      end
    endcase
    return s;
  endfunction

  // Number of system cycles in the current period. The half-step mode uses
  // long_leg to choose between its short (5) and long (6) periods.
  function automatic logic [LEN_W-1:0] period_len(input div_mode_e m,
                                                  input logic long_leg);
    logic [LEN_W-1:0] n;
    case (m)
      M_ONE:       n = LEN_W'(1);
      M_TWO:       n = LEN_W'(2);
      M_THREE:     n = LEN_W'(3);
      M_FOUR:      n = LEN_W'(4);
      M_FIVE_HALF: n = long_leg ? LEN_W'(6) : LEN_W'(5);
      M_SIX:       n = LEN_W'(6);
      default:     n = LEN_W'(1);
    endcase
    return n;
  endfunction

endpackage

// File: rtl/osr_sel_decode.sv
module osr_sel_decode
  import osr_div_pkg::*;
(
  input  logic [2:0] code,
  output div_mode_e  mode,
  output logic       reserved
);

  sel_t dec;

  always_comb begin
    dec      = decode_sel(code);
    mode     = dec.mode;
    reserved = dec.reserved;
  end

  // R5: a reserved code must decode to ratio 1
  always_comb begin
    if (reserved) begin
      rsv_as_one_chk: assert (mode == M_ONE);
    end
  end

endmodule

// File: rtl/osr_period_ctr.sv
module osr_period_ctr
  import osr_div_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      live,
  input  div_mode_e mode_next,
  output logic      tick,
  output div_mode_e mode_act,
  output logic      long_leg
);

  localparam logic [LEN_W-1:0] ONE_L = LEN_W'(1);

  logic [LEN_W-1:0] cnt;
  logic [LEN_W-1:0] len;
  logic             stay_half;

  assign len       = period_len(mode_act, long_leg);
  assign tick      = live && (cnt == len - ONE_L);
  assign stay_half = (mode_act == M_FIVE_HALF) && (mode_next == M_FIVE_HALF);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      mode_act <= M_ONE;
      long_leg <= 1'b0;
    end else if (live) begin
      if (tick) begin
        cnt      <= '0;
        mode_act <= mode_next;
        long_leg <= stay_half ? ~long_leg : 1'b0;
      end else begin
        cnt <= cnt + ONE_L;
      end
    end
  end

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < len);

  // R2
  one_every_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live && mode_act == M_ONE) |-> tick);

  // R4
  half_alternate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && stay_half) |=> (long_leg != $past(long_leg)));

  // R7
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(mode_act));

endmodule

// File: rtl/osr_half_stage.sv
module osr_half_stage (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_in,
  output logic tick_out
);

  logic phase;

  assign tick_out = tick_in && phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase <= 1'b0;
    else if (tick_in) phase <= ~phase;
  end

  // R8
  half_inside_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_out |-> tick_in);

  // R8
  half_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick_out |=> !tick_out);

endmodule

// File: rtl/osr_clk_div.sv
module osr_clk_div
  import osr_div_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] ratio_sel,
  output logic       tick_256,
  output logic       tick_128,
  output logic       ratio_err
);

  logic      live;
  div_mode_e mode_next;
  div_mode_e mode_act;
  logic      rsv_in;
  logic      long_leg;
  logic      bound;
  logic      rsv_taken;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live <= 1'b0;
    else        live <= 1'b1;
  end

  osr_sel_decode u_dec (
    .code     (ratio_sel),
    .mode     (mode_next),
    .reserved (rsv_in)
  );

  osr_period_ctr u_ctr (
    .clk       (clk),
    .rst_n     (rst_n),
    .live      (live),
    .mode_next (mode_next),
    .tick      (bound),
    .mode_act  (mode_act),
    .long_leg  (long_leg)
  );

  osr_half_stage u_half (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_in  (bound),
    .tick_out (tick_128)
  );

  assign tick_256  = bound;
  assign rsv_taken = bound && rsv_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         ratio_err <= 1'b0;
    else if (rsv_taken) ratio_err <= 1'b1;
  end

  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ratio_err |=> ratio_err);

  // R6
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ratio_err) |-> $past(rsv_taken));

  // R1
  first_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(live) |-> (mode_act == M_ONE && !long_leg));

endmodule

// File: tb/tb_osr_clk_div.sv
module tb_osr_clk_div;

  logic       clk;
  logic       rst_n;
  logic [2:0] ratio_sel;
  logic       tick_256;
  logic       tick_128;
  logic       ratio_err;

  int  n_chk  = 0;
  int  n_fail = 0;
  bit  done   = 0;

  typedef struct {
    int    gap;
    string tag;
  } exp_t;

  exp_t exp_q[$];

  osr_clk_div dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .ratio_sel (ratio_sel),
    .tick_256  (tick_256),
    .tick_128  (tick_128),
    .ratio_err (ratio_err)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // Expected period of pulse number idx after a code is applied.
  function automatic int exp_gap(input logic [2:0] code, input int idx);
    case (code)
      3'b010:  return 2;
      3'b011:  return 3;
      3'b100:  return 4;
      3'b110:  return 6;
      3'b101:  return (idx % 2 == 0) ? 5 : 6;
      default: return 1;
    endcase
  endfunction

  function automatic string code_tag(input logic [2:0] code);
    if (code == 3'b000)                   return "R2";
    if (code == 3'b001 || code == 3'b111) return "R5";
    if (code == 3'b101)                   return "R4";
    return "R3";
  endfunction

  // Monitor: measures pulse spacing and the 128x phase.
  int cyc   = 0;
  int last  = -1;
  int pcnt  = 0;
  always @(negedge clk) begin
    if (!rst_n) begin
      last = -1;
      pcnt = 0;
    end else begin
      cyc++;
      if (tick_128 && !tick_256) chk(0, "R8 tick_128 outside tick_256", 1, 0);
      if (tick_256) begin
        pcnt++;
        chk(tick_128 == (pcnt % 2 == 0), "R8 tick_128 phase", int'(tick_128),
            int'(pcnt % 2 == 0));
        if (last >= 0 && exp_q.size() > 0) begin
          exp_t e;
          e = exp_q.pop_front();
          chk((cyc - last) == e.gap, e.tag, cyc - last, e.gap);
        end
        last = cyc;
      end
    end
  end

  task automatic wait_tick();
    do @(negedge clk); while (!tick_256);
  endtask

  // Apply a code right at a period boundary; the next period uses it.
  task automatic step(input logic [2:0] code, input int n);
    wait_tick();
    #1;
    ratio_sel = code;
    for (int i = 0; i < n; i++) exp_q.push_back('{exp_gap(code, i), code_tag(code)});
    wait (exp_q.size() == 0);
  endtask

  // Change the code two cycles into a 6-cycle period (R7).
  task automatic mid_change(input logic [2:0] code, input int n);
    wait_tick();
    @(negedge clk);
    @(negedge clk);
    #1;
    ratio_sel = code;
    exp_q.push_back('{6, "R7 current period keeps old ratio"});
    for (int i = 0; i < n; i++) exp_q.push_back('{exp_gap(code, i), "R7 new ratio after boundary"});
    wait (exp_q.size() == 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(tick_256 == 0, "R1 tick_256 in reset", int'(tick_256), 0);
    chk(tick_128 == 0, "R1 tick_128 in reset", int'(tick_128), 0);
    chk(ratio_err == 0, "R1 ratio_err in reset", int'(ratio_err), 0);
    #1;
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    ratio_sel = 3'b011;
    do_reset();
    // R1: ratio 1 right after reset although the selector asks for 3
    @(negedge clk);
    chk(tick_256 == 1, "R1 ratio 1 after reset", int'(tick_256), 1);
    step(3'b000, 8);
    step(3'b010, 6);
    step(3'b011, 6);
    step(3'b100, 6);
    step(3'b110, 4);
    mid_change(3'b010, 4);
    step(3'b110, 3);
    step(3'b101, 8);
    step(3'b011, 4);
    chk(ratio_err == 0, "R6 no reserved code yet", int'(ratio_err), 0);
    step(3'b001, 6);
    @(negedge clk);
    chk(ratio_err == 1, "R6 flag after reserved", int'(ratio_err), 1);
    step(3'b100, 4);
    chk(ratio_err == 1, "R6 flag sticky", int'(ratio_err), 1);
    ratio_sel = 3'b000;
    do_reset();
    @(negedge clk);
    chk(ratio_err == 0, "R6 flag cleared by reset", int'(ratio_err), 0);
    step(3'b111, 5);
    @(negedge clk);
    chk(ratio_err == 1, "R6 flag after code 111", int'(ratio_err), 1);
    step(3'b101, 6);
    finish_run();
  end

endmodule